// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

The builder accepts a list of memory segments, each an address and a byte length, and writes one 128-bit descriptor entry per chunk into a table memory through a write port that takes a whole entry at a time. No descriptor may span a 64 KiB address boundary, so a segment that crosses one or more boundaries is split into several chunks. Every word of an entry is stored in big-endian byte order.

A list begins with a `start_i` pulse. Segments then arrive over a valid/ready handshake, and `seg_last_i` marks the final segment of the list. When the list is complete the builder rewrites the last entry with its end-of-list flag set. It then pulses `done_o` and presents the number of entries on `count_o`. If the list needs more entries than the table holds, the builder abandons the table. It reports `overflow_o` together with a count of zero, so the caller can move the data by programmed I/O instead. A zero-length segment ends the list early.

Top module: `sgt_table_builder`

## Requirements
- R1: Each entry is written on `tbl_wdata_o` as four 32-bit words, from most significant to least significant: bits [127:96] are zero, bits [95:64] hold the chunk address, bits [63:32] are zero, and bits [31:0] hold the length word. The length word carries the chunk length in bits 15:0, the end-of-list flag in bit 31, and zeros in bits 30:16. Each word is byte-swapped before it is written, so the end-of-list flag appears at `tbl_wdata_o[7]`.
- R2: The length of each chunk is the smaller of two values: 0x10000 minus the low 16 bits of the current address, or the bytes left in the segment. The next chunk starts at the current address plus that length.
- R3: A chunk of exactly 65536 bytes is written with a length field of zero.
- R4: Entries are first written with the end-of-list flag clear. When the list completes with at least one entry, the final entry is written a second time, at the same index and with the flag set. This second write is the last write before `done_o`.
- R5: The entries of a list are written at consecutive table indices, starting from 0, in segment order and then in chunk order.
- R6: At most CAP entries are written. When the list needs more, the builder stops writing entries and consumes the remaining segments up to `seg_last_i`. It then raises `done_o` with `overflow_o`=1 and `count_o`=0, and no entry is written with the end-of-list flag set.
- R7: A zero-length segment ends the list. The segments after it, up to `seg_last_i`, are accepted without producing any entry. If the first segment has zero length, the list completes with `count_o`=0 and no table write.
- R8: `done_o` is high for exactly one cycle. In that cycle `count_o` gives the number of entries in the table.
- R9: While in reset and just after it, `done_o`, `tbl_we_o` and `seg_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new list (accepted when idle) |
| seg_valid_i | input | 1 | A segment is offered |
| seg_ready_o | output | 1 | The builder accepts a segment |
| seg_addr_i | input | 32 | Segment start address |
| seg_len_i | input | LEN_W | Segment length in bytes |
| seg_last_i | input | 1 | This segment ends the list |
| tbl_we_o | output | 1 | Table entry write strobe |
| tbl_idx_o | output | IDX_W | Table entry index |
| tbl_wdata_o | output | 128 | Big-endian descriptor entry |
| done_o | output | 1 | List complete (one-cycle pulse) |
| count_o | output | CNT_W | Number of entries, valid with done_o |
| overflow_o | output | 1 | Table capacity exceeded, valid with done_o |

## Verification
A wrong remaining-length or address register shows up at the very next write. The chunk length or address in that entry is wrong, or the segment yields the wrong number of entries, and that error in turn displaces the index of every later entry. A wrong entry counter shows up either as an early or missed overflow, or as the end-of-list rewrite landing on the wrong index. Both are visible when `done_o` pulses. A missing or misplaced end-of-list flag changes the number of table writes and the content of the final entry. Both are checked on the cycle of `done_o`.

// File: rtl/sgt_pkg.sv
package sgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_TAKE, ST_SPLIT, ST_MARK, ST_DRAIN, ST_DONE
  } state_e;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/sgt_chunker.sv
module sgt_chunker #(
  parameter int LEN_W = 20
) (
  input  logic [31:0]      addr_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [LEN_W-1:0] chunk_o,
  output logic             last_o
);
  logic [16:0]      room;
  logic [LEN_W-1:0] room_w;

  // bytes left before the next 64 KiB boundary: 1..65536
  assign room    = 17'h10000 - {1'b0, addr_i[15:0]};
  assign room_w  = LEN_W'(room);
  assign chunk_o = (rem_i < room_w) ? rem_i : room_w;
  assign last_o  = (rem_i == chunk_o);
endmodule

// File: rtl/sgt_entry_fmt.sv
module sgt_entry_fmt
  import sgt_pkg::*;
(
  input  logic [31:0]  addr_i,
  input  logic [15:0]  len_i,
  input  logic         eol_i,
  output logic [127:0] entry_o
);
  logic [31:0] len_word;

  assign len_word = {eol_i, 15'h0, len_i};
  assign entry_o  = {32'h0, bswap32(addr_i), 32'h0, bswap32(len_word)};
endmodule

// File: rtl/sgt_entry_ctr.sv
module sgt_entry_ctr #(
  parameter int CAP   = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_o <= '0;
    else if (clr_i) count_o <= '0;
    else if (inc_i) count_o <= count_o + CNT_W'(1);
  end

  assign full_o = (count_o == CNT_W'(CAP));
endmodule

// File: rtl/sgt_table_builder.sv
module sgt_table_builder
  import sgt_pkg::*;
#(
  parameter int CAP   = 64,
  parameter int LEN_W = 20,
  localparam int IDX_W = (CAP > 1) ? $clog2(CAP) : 1,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             seg_valid_i,
  output logic             seg_ready_o,
  input  logic [31:0]      seg_addr_i,
  input  logic [LEN_W-1:0] seg_len_i,
  input  logic             seg_last_i,
  output logic             tbl_we_o,
  output logic [IDX_W-1:0] tbl_idx_o,
  output logic [127:0]     tbl_wdata_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o,
  output logic             overflow_o
);
  state_e           state, state_nx;
  logic [31:0]      cur_addr, last_addr;
  logic [LEN_W-1:0] rem, chunk;
  logic [15:0]      last_len;
  logic             seg_is_last, ovf, chunk_last;
  logic [CNT_W-1:0] count;
  logic             full, ctr_clr, ctr_inc;
  logic             take, emit;

  sgt_chunker #(.LEN_W(LEN_W)) i_chunker (
    .addr_i (cur_addr),
    .rem_i  (rem),
    .chunk_o(chunk),
    .last_o (chunk_last)
  );

  sgt_entry_ctr #(.CAP(CAP), .CNT_W(CNT_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctr_clr),
    .inc_i  (ctr_inc),
    .count_o(count),
    .full_o (full)
  );

  logic        mark;
  logic [31:0] fmt_addr;
  logic [15:0] fmt_len;

  assign mark     = (state == ST_MARK);
  assign fmt_addr = mark ? last_addr : cur_addr;
  assign fmt_len  = mark ? last_len : chunk[15:0];

  sgt_entry_fmt i_fmt (
    .addr_i (fmt_addr),
    .len_i  (fmt_len),
    .eol_i  (mark),
    .entry_o(tbl_wdata_o)
  );

  assign seg_ready_o = (state == ST_TAKE) || (state == ST_DRAIN);
  assign take        = seg_ready_o && seg_valid_i;
  assign emit        = (state == ST_SPLIT) && !full;
  assign ctr_clr     = (state == ST_IDLE) && start_i;
  assign ctr_inc     = emit;
  assign tbl_we_o    = emit || mark;
  assign tbl_idx_o   = IDX_W'(mark ? count - CNT_W'(1) : count);
  assign done_o      = (state == ST_DONE);
  assign overflow_o  = done_o && ovf;
  assign count_o     = (done_o && !ovf) ? count : '0;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start_i) state_nx = ST_TAKE;
      ST_TAKE:
        if (seg_valid_i) begin
          if (seg_len_i != '0)  state_nx = ST_SPLIT;
          else if (!seg_last_i) state_nx = ST_DRAIN;
          else                  state_nx = (count != '0) ? ST_MARK : ST_DONE;
        end
      ST_SPLIT:
        if (full)            state_nx = seg_is_last ? ST_DONE : ST_DRAIN;
        else if (chunk_last) state_nx = seg_is_last ? ST_MARK : ST_TAKE;
      ST_MARK:  state_nx = ST_DONE;
      ST_DRAIN:
        if (seg_valid_i && seg_last_i)
          state_nx = (!ovf && count != '0) ? ST_MARK : ST_DONE;
      ST_DONE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      cur_addr    <= '0;
      rem         <= '0;
      seg_is_last <= 1'b0;
      ovf         <= 1'b0;
      last_addr   <= '0;
      last_len    <= '0;
    end else begin
      state <= state_nx;
      if (ctr_clr) ovf <= 1'b0;
      if (state == ST_TAKE && take && seg_len_i != '0) begin
        cur_addr    <= seg_addr_i;
        rem         <= seg_len_i;
        seg_is_last <= seg_last_i;
      end
      if (state == ST_SPLIT && full) ovf <= 1'b1;
      if (emit) begin
        cur_addr  <= cur_addr + 32'(chunk);
        rem       <= rem - chunk;
        last_addr <= cur_addr;
        last_len  <= chunk[15:0];
      end
    end
  end

  AST_CHUNK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit |-> (chunk != '0) && (chunk <= rem) &&
             (({2'b0, cur_addr[15:0]} + 18'(chunk)) <= 18'h10000)); // R2
  AST_EOL_THEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we_o && tbl_wdata_o[7]) |=> done_o); // R4
  AST_IDX_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit && $past(emit)) |-> tbl_idx_o == IDX_W'($past(tbl_idx_o) + IDX_W'(1))); // R5
  AST_OVF_NO_EOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> !$past(tbl_we_o && tbl_wdata_o[7])); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
endmodule

// File: tb/test_sgt_table_builder.sv
module test_sgt_table_builder;
  localparam int CAP   = 8;
  localparam int LEN_W = 20;
  localparam int IDX_W = $clog2(CAP);
  localparam int CNT_W = $clog2(CAP + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             seg_valid = 1'b0;
  logic             seg_ready;
  logic [31:0]      seg_addr = '0;
  logic [LEN_W-1:0] seg_len = '0;
  logic             seg_last = 1'b0;
  logic             tbl_we;
  logic [IDX_W-1:0] tbl_idx;
  logic [127:0]     tbl_wdata;
  logic             done;
  logic [CNT_W-1:0] count;
  logic             overflow;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sgt_table_builder #(.CAP(CAP), .LEN_W(LEN_W)) i_sgt_table_builder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .seg_valid_i(seg_valid), .seg_ready_o(seg_ready),
    .seg_addr_i(seg_addr), .seg_len_i(seg_len), .seg_last_i(seg_last),
    .tbl_we_o(tbl_we), .tbl_idx_o(tbl_idx), .tbl_wdata_o(tbl_wdata),
    .done_o(done), .count_o(count), .overflow_o(overflow)
  );

  logic [127:0] mem [CAP];
  int wr_cnt = 0;
  always @(posedge clk) if (tbl_we) begin
    mem[tbl_idx] = tbl_wdata;
    wr_cnt++;
  end

  logic [31:0]      sa [8];
  logic [LEN_W-1:0] sl [8];
  int               ns;
  logic [31:0]      ea [16];
  logic [15:0]      el [16];
  int               en;
  bit               eovf;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bs(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic model();
    en = 0; eovf = 0;
    for (int i = 0; i < ns && !eovf; i++) begin
      int a, r;
      if (sl[i] == 0) break;
      a = int'(sa[i]); r = int'(sl[i]);
      while (r > 0 && !eovf) begin
        int room, c;
        room = 32'h10000 - (a & 32'hFFFF);
        c = (r < room) ? r : room;
        if (en >= CAP) eovf = 1;
        else begin
          ea[en] = a; el[en] = c[15:0]; en++;
          a += c; r -= c;
        end
      end
    end
  endtask

  task automatic run_list(input string req);
    logic [CNT_W-1:0] got_cnt;
    logic             got_ovf;
    int               exp_wr;
    model();
    @(negedge clk);
    wr_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < ns; i++) begin
      seg_valid = 1'b1; seg_addr = sa[i]; seg_len = sl[i];
      seg_last = (i == ns - 1);
      while (!seg_ready) @(negedge clk);
      @(negedge clk);
    end
    seg_valid = 1'b0; seg_last = 1'b0;
    while (!done) @(negedge clk);
    got_cnt = count; got_ovf = overflow;
    check(got_ovf == eovf, {req, " R6 overflow"}, 128'(got_ovf), 128'(eovf));
    check(int'(got_cnt) == (eovf ? 0 : en), {req, " R8 count"},
          128'(got_cnt), 128'(eovf ? 0 : en));
    exp_wr = eovf ? CAP : ((en > 0) ? en + 1 : 0);
    check(wr_cnt == exp_wr, {req, " R4 R7 write count"}, 128'(wr_cnt), 128'(exp_wr));
    if (!eovf)
      for (int k = 0; k < en; k++) begin
        logic [127:0] ex;
        ex = {32'h0, bs(ea[k]), 32'h0, bs({(k == en - 1), 15'h0, el[k]})};
        check(mem[k] == ex, {req, " R1 R5 entry"}, mem[k], ex);
      end
    @(negedge clk);
    check(!done, {req, " R8 done pulse"}, 128'(done), 128'(0));
  endtask

  task automatic t_single();
    ns = 1; sa[0] = 32'h1000_0000; sl[0] = 20'h200;
    run_list("R2 single");
  endtask

  task automatic t_cross();
    ns = 1; sa[0] = 32'h0001_FF00; sl[0] = 20'h300;
    run_list("R2 cross");
  endtask

  task automatic t_full64k();
    ns = 1; sa[0] = 32'h0003_0000; sl[0] = 20'h10000;
    run_list("R3 full64k");
    check(mem[0][31:0] == 32'h0000_0080, "R3 length word", 128'(mem[0][31:0]),
          128'(32'h0000_0080));
  endtask

  task automatic t_multi();
    ns = 3;
    sa[0] = 32'h0004_8000; sl[0] = 20'h18000;
    sa[1] = 32'h9000_0010; sl[1] = 20'h20;
    sa[2] = 32'h7FFF_FFF0; sl[2] = 20'h40;
    run_list("R5 multi");
  endtask

  task automatic t_zero_first();
    ns = 2;
    sa[0] = 32'h0; sl[0] = '0;
    sa[1] = 32'h1000; sl[1] = 20'h100;
    run_list("R7 zero first");
  endtask

  task automatic t_zero_mid();
    ns = 3;
    sa[0] = 32'h2000; sl[0] = 20'h100;
    sa[1] = 32'h5000; sl[1] = '0;
    sa[2] = 32'h6000; sl[2] = 20'h100;
    run_list("R7 zero mid");
  endtask

  task automatic t_exact_cap();
    ns = 1; sa[0] = 32'h0; sl[0] = 20'h80000;
    run_list("R6 exact cap");
  endtask

  task automatic t_overflow();
    ns = 2;
    sa[0] = 32'h0; sl[0] = 20'h80000;
    sa[1] = 32'h0010_0000; sl[1] = 20'h10;
    run_list("R6 overflow");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !tbl_we && !seg_ready, "R9 in reset",
          {125'b0, done, tbl_we, seg_ready}, 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !tbl_we && !seg_ready, "R9 after reset",
          {125'b0, done, tbl_we, seg_ready}, 128'(0));
    t_single();
    t_cross();
    t_full64k();
    t_multi();
    t_zero_first();
    t_zero_mid();
    t_exact_cap();
    t_overflow();
    t_single();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule